// File: doc/BRIEF.md
# Deferred Masked Register Write-Back Buffer

This block gathers the register updates produced while one instruction executes. It holds them aside until the instruction is known to complete, then applies all of them in a single clock edge. If the instruction is abandoned, the whole group is thrown away instead. Each queued update names a destination and carries a data word and a keep-mask. At commit the destination becomes the old value ANDed with the mask, then ORed with the data. A mask of zero is therefore a plain overwrite. A non-zero mask lets one field of a register change while the rest is kept.

The destinations are part of the block. There are sixteen 16-bit general registers and two 40-bit accumulators, and each has a read port. The read ports always show committed contents. Logic that executes in the same cycle as a queued write therefore still sees the old values.

Top module: `deferred_wb`

## Requirements
- R1: After reset, every general register and accumulator reads zero, the pending count is zero and the overflow flag is low.
- R2: A queued write does not change any read port until it is committed; reads always return committed state.
- R3: On commit, each destination becomes (old AND mask) OR data. For a general register only the low 16 bits of data and mask are used.
- R4: A write with a zero mask fully replaces the destination with its data.
- R5: Commit applies entries from the oldest to the newest. When several entries hit the same destination, the later entry acts on the result of the earlier one, so the last plain write wins.
- R6: Discard empties the queue and writes nothing. When commit and discard are asserted together, discard wins and no register changes.
- R7: A destination code with bit 4 set selects an accumulator, and bit 0 picks which one. Bit 4 clear selects the general register given by bits 3:0. Data and mask for an accumulator are cut to their low 40 bits when they are queued.
- R8: The queue holds 16 entries. A write request made while it is full, in a cycle with neither commit nor discard, is dropped and sets an overflow flag. Only reset clears that flag.
- R9: A write request in the same cycle as a commit or a discard becomes entry 0 of the next group. It is neither applied by that commit nor dropped by that discard.
- R10: The pending-count output equals the number of queued entries, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Queue one write request |
| wr_dst | input | 5 | Destination code (bit 4: accumulator select) |
| wr_data | input | 48 | Data word to OR in |
| wr_mask | input | 48 | Keep-mask ANDed with the old value |
| commit | input | 1 | Apply all queued entries in order |
| discard | input | 1 | Drop all queued entries |
| rd_gpr_sel | input | 4 | General register read index |
| rd_gpr | output | 16 | Committed general register value |
| rd_acc_sel | input | 1 | Accumulator read index |
| rd_acc | output | 40 | Committed accumulator value |
| pend_cnt | output | 5 | Number of queued entries |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets cases where ordering matters.

- Two masked writes to one register in a single group check that each entry sees the result of the one before it. A design that applies the entries in parallel, or from old state, would lose the first field.
- Commit and discard are raised together. A design that gives commit priority would write registers that should stay untouched.
- A write arrives in the commit cycle. A design that folds it into the current group, or clears it with the old group, shows the register too early or never.
- A full queue receives a seventeenth request. The bench checks that the request is dropped and that the flag stays set after later commits and discards.
- Accumulator writes carry data above bit 39. A design that does not truncate them, or that applies the mask wrongly, corrupts the kept bits.

// File: rtl/deferred_wb.sv
module deferred_wb #(
  parameter int NGPR  = 16,
  parameter int GW    = 16,
  parameter int NACC  = 2,   // power of two
  parameter int AW    = 40,
  parameter int IW    = 48,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NGPR):0]      wr_dst,
  input  logic [IW-1:0]              wr_data,
  input  logic [IW-1:0]              wr_mask,
  input  logic                       commit,
  input  logic                       discard,
  input  logic [$clog2(NGPR)-1:0]    rd_gpr_sel,
  output logic [GW-1:0]              rd_gpr,
  input  logic [$clog2(NACC)-1:0]    rd_acc_sel,
  output logic [AW-1:0]              rd_acc,
  output logic [$clog2(DEPTH+1)-1:0] pend_cnt,
  output logic                       ovf
);
  localparam int IDXW = $clog2(NGPR);
  localparam int ASW  = $clog2(NACC);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int SW   = $clog2(DEPTH);

  logic [NGPR-1:0][GW-1:0] gpr, gpr_n;
  logic [NACC-1:0][AW-1:0] acc, acc_n;
  logic [IDXW:0]           q_dst  [DEPTH];
  logic [AW-1:0]           q_data [DEPTH];
  logic [AW-1:0]           q_mask [DEPTH];
  logic [CW-1:0]           cnt;
  logic                    flush, accept;
  logic [SW-1:0]           slot;
  logic                    unused_hi;

  assign flush     = commit | discard;
  assign accept    = wr_en && (flush || cnt < CW'(DEPTH));
  assign slot      = flush ? '0 : cnt[SW-1:0];
  assign rd_gpr    = gpr[rd_gpr_sel];
  assign rd_acc    = acc[rd_acc_sel];
  assign pend_cnt  = cnt;
  assign unused_hi = ^{wr_data[IW-1:AW], wr_mask[IW-1:AW]};

  always_comb begin
    gpr_n = gpr;
    acc_n = acc;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt)) begin
        if (q_dst[i][IDXW])
          acc_n[q_dst[i][ASW-1:0]] = (acc_n[q_dst[i][ASW-1:0]] & q_mask[i]) | q_data[i];
        else
          gpr_n[q_dst[i][IDXW-1:0]] = (gpr_n[q_dst[i][IDXW-1:0]] & q_mask[i][GW-1:0])
                                      | q_data[i][GW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      q_dst[slot]  <= wr_dst;
      q_data[slot] <= wr_data[AW-1:0];
      q_mask[slot] <= wr_mask[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpr <= '0;
      acc <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (commit && !discard) begin
        gpr <= gpr_n;
        acc <= acc_n;
      end
      cnt <= (flush ? '0 : cnt) + CW'(accept);
      if (wr_en && !accept) ovf <= 1'b1;
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !flush |=> $stable(cnt));
  // R2
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && !discard) |=> $stable(gpr) && $stable(acc));
  // R6
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> cnt == {{(CW-1){1'b0}}, $past(wr_en)});
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flush && cnt == CW'(DEPTH) |=> ovf && cnt == CW'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
endmodule

// File: tb/tb_deferred_wb.sv
module tb_deferred_wb;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, commit = 0, discard = 0;
  logic [4:0]  wr_dst = '0;
  logic [47:0] wr_data = '0, wr_mask = '0;
  logic [3:0]  rd_gpr_sel = '0;
  logic        rd_acc_sel = 0;
  logic [15:0] rd_gpr;
  logic [39:0] rd_acc;
  logic [4:0]  pend_cnt;
  logic        ovf;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  deferred_wb dut (.clk, .rst_n, .wr_en, .wr_dst, .wr_data, .wr_mask, .commit, .discard,
                   .rd_gpr_sel, .rd_gpr, .rd_acc_sel, .rd_acc, .pend_cnt, .ovf);

  // {op(0 write,1 commit,2 discard), dst, data, mask, check reg, expected}
  localparam logic [57:0] TBL [0:12] = '{
    {2'd0, 4'd3, 16'h1234, 16'h0000, 4'd3, 16'h0000},  // R2
    {2'd1, 4'd0, 16'h0000, 16'h0000, 4'd3, 16'h1234},  // R4
    {2'd0, 4'd3, 16'h00A0, 16'hFF0F, 4'd3, 16'h1234},  // R2
    {2'd1, 4'd0, 16'h0000, 16'h0000, 4'd3, 16'h12A4},  // R3
    {2'd0, 4'd5, 16'h1111, 16'h0000, 4'd5, 16'h0000},
    {2'd0, 4'd5, 16'h2222, 16'h0000, 4'd5, 16'h0000},
    {2'd1, 4'd0, 16'h0000, 16'h0000, 4'd5, 16'h2222},  // R5
    {2'd0, 4'd5, 16'h0001, 16'hFFF0, 4'd5, 16'h2222},
    {2'd0, 4'd5, 16'h0010, 16'hFF0F, 4'd5, 16'h2222},
    {2'd1, 4'd0, 16'h0000, 16'h0000, 4'd5, 16'h2211},  // R5
    {2'd0, 4'd7, 16'hBEEF, 16'h0000, 4'd7, 16'h0000},
    {2'd2, 4'd0, 16'h0000, 16'h0000, 4'd7, 16'h0000},  // R6
    {2'd1, 4'd0, 16'h0000, 16'h0000, 4'd7, 16'h0000}   // R6
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [4:0] d, input logic [47:0] dat,
                    input logic [47:0] msk, input logic cm, input logic dc);
    wr_en = we; wr_dst = d; wr_data = dat; wr_mask = msk; commit = cm; discard = dc;
    @(posedge clk); #1;
    wr_en = 0; commit = 0; discard = 0;
  endtask

  function automatic logic [15:0] gread(input logic [3:0] r);
    return dut.rd_gpr_sel == r ? rd_gpr : 16'hxxxx;
  endfunction

  task automatic rg(input logic [3:0] r, output logic [15:0] v);
    rd_gpr_sel = r; #1; v = rd_gpr;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int r = 0; r < 16; r++) begin rg(4'(r), v); chk("R1 gpr", 40'(v), 40'h0); end
    rd_acc_sel = 0; #1 chk("R1 acc0", rd_acc, 40'h0);
    rd_acc_sel = 1; #1 chk("R1 acc1", rd_acc, 40'h0);
    chk("R1 count", 40'(pend_cnt), 40'h0);
    chk("R1 ovf", 40'(ovf), 40'h0);

    for (int i = 0; i < 13; i++) begin
      logic [57:0] t;
      t = TBL[i];
      op(t[57:56] == 2'd0, {1'b0, t[55:52]}, {32'h0, t[51:36]}, {32'h0, t[35:20]},
         t[57:56] == 2'd1, t[57:56] == 2'd2);
      rg(t[19:16], v);
      chk("R2/R3/R4/R5/R6 table", 40'(v), 40'(t[15:0]));
    end

    // R7 accumulator truncation and mask
    op(1, 5'b10000, 48'hAB_CD12345678, 48'h0, 0, 0);
    op(0, 5'd0, 48'h0, 48'h0, 1, 0);
    rd_acc_sel = 0; #1 chk("R7 acc0 truncated", rd_acc, 40'hCD12345678);
    rd_acc_sel = 1; #1 chk("R7 acc1 untouched", rd_acc, 40'h0);
    op(1, 5'b10000, 48'h77_00000000FF, 48'hFF_FFFFFFFF00, 0, 0);
    op(0, 5'd0, 48'h0, 48'h0, 1, 0);
    rd_acc_sel = 0; #1 chk("R7 acc0 masked", rd_acc, 40'hCD123456FF);

    // R10 pending count
    op(1, 5'd1, 48'h1, 48'h0, 0, 0);
    op(1, 5'd1, 48'h2, 48'h0, 0, 0);
    op(1, 5'd1, 48'h3, 48'h0, 0, 0);
    chk("R10 count three", 40'(pend_cnt), 40'd3);
    op(0, 5'd0, 48'h0, 48'h0, 0, 1);
    chk("R10 count after discard", 40'(pend_cnt), 40'd0);

    // R6 commit and discard together
    op(1, 5'd9, 48'h5555, 48'h0, 0, 0);
    op(0, 5'd0, 48'h0, 48'h0, 1, 1);
    rg(4'd9, v); chk("R6 discard wins", 40'(v), 40'h0);
    chk("R6 empty", 40'(pend_cnt), 40'd0);

    // R9 write in the commit cycle
    op(1, 5'd1, 48'h0101, 48'h0, 0, 0);
    op(1, 5'd2, 48'h0202, 48'h0, 1, 0);
    rg(4'd1, v); chk("R9 old group applied", 40'(v), 40'h0101);
    rg(4'd2, v); chk("R9 new write held", 40'(v), 40'h0);
    chk("R9 new group count", 40'(pend_cnt), 40'd1);
    op(0, 5'd0, 48'h0, 48'h0, 1, 0);
    rg(4'd2, v); chk("R9 new write applied", 40'(v), 40'h0202);

    // R8 overflow
    for (int i = 1; i <= 16; i++) op(1, 5'd10, 48'(i), 48'h0, 0, 0);
    chk("R8 full count", 40'(pend_cnt), 40'd16);
    chk("R8 no ovf yet", 40'(ovf), 40'h0);
    op(1, 5'd10, 48'h9999, 48'h0, 0, 0);
    chk("R8 ovf set", 40'(ovf), 40'h1);
    chk("R8 count held", 40'(pend_cnt), 40'd16);
    op(0, 5'd0, 48'h0, 48'h0, 1, 0);
    rg(4'd10, v); chk("R8 extra dropped", 40'(v), 40'h0010);
    op(0, 5'd0, 48'h0, 48'h0, 0, 1);
    chk("R8 ovf sticky", 40'(ovf), 40'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule